// File: doc/BRIEF.md
# Dual-Mode General-Purpose Output Controller

This block drives two output-only general-purpose pins. Software programs it through an index/data pair on a configuration bus. One write latches an index, and later data writes go to the register that index selects. A shared control register gives each pin two settings: an operating mode and a strobe-gate enable. Each pin also has its own write-only register, which holds an Off-state polarity bit and a 7-bit compare value.

In power-management mode a pin reports the power-management unit's state. The pin is High while the unit is not in Off. Once the unit is in Off, the pin takes the level that the polarity bit selects. In address-decode mode the pin is an active-low select that follows system address bits 9..3. Pin A can optionally be qualified with the active I/O write strobe, and pin B with the active I/O read strobe.

Each pin is run by a small state machine. Its states are `ST_PWR_ON` (power mode, unit active, pin High), `ST_OFF_HIGH` (power mode, unit Off, polarity 0, pin High), `ST_OFF_LOW` (power mode, unit Off, polarity 1, pin Low), `ST_DEC_MISS` (decode mode, no qualified match, pin High) and `ST_DEC_HIT` (decode mode, qualified match, pin Low). On every clock the machine moves to the state that the current inputs select:
- A pin in decode mode goes to `ST_DEC_HIT` on a qualified match and to `ST_DEC_MISS` otherwise.
- A pin in power mode goes to `ST_PWR_ON` when the unit is not Off.
- A pin in power mode with the unit Off goes to `ST_OFF_LOW` or `ST_OFF_HIGH`, according to the polarity bit.

Any state can reach any other state in one step. The pin level is decoded from the state alone.

Top module: `gpo_dual_ctrl`

## Requirements
- R1: Reset clears every register, including the latched index. After reset both pins are in power-management mode with gating off and polarity 0, so both pins are High, even if the unit is Off.
- R2: A write on `cfg_idx_wr` latches `cfg_wdata` as the index. Each write on `cfg_data_wr` goes to the register at the latched index, and the index stays latched across any number of data writes. The indexes are: control 0x21, pin A 0x23, pin B 0x24.
- R3: In power-management mode, with `pmu_off` low, the pin is High.
- R4: In power-management mode, with `pmu_off` high, the pin is Low when bit 7 of its register is 1 and High when that bit is 0.
- R5: In ungated address-decode mode, the pin is Low exactly while `sys_addr` equals bits 6..0 of its register. It ignores `pmu_off`, bit 7 of its register and the strobes.
- R6: With gating enabled in decode mode, pin A is Low only when the address matches and `io_wr_act` is high. Pin B is Low only when the address matches and `io_rd_act` is high.
- R7: A change on any input or register reaches the pin exactly one clock after it is sampled. A change is not visible before that edge.
- R8: In the control register, bit 0 selects pin A's mode (1 = decode) and bit 1 enables pin A's gate. Bits 2 and 3 do the same for pin B. Bits 7..4 have no effect.
- R9: Data writes to index 0x22, to indexes 0x25–0x28, or to any other index not listed in R2 leave every register and both pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idx_wr | input | 1 | Latch `cfg_wdata` as the register index |
| cfg_data_wr | input | 1 | Write `cfg_wdata` to the indexed register |
| cfg_wdata | input | 8 | Configuration write data |
| pmu_off | input | 1 | Power-management unit is in its Off state |
| sys_addr | input | 7 | System address bits 9..3 |
| io_wr_act | input | 1 | I/O write strobe, active high |
| io_rd_act | input | 1 | I/O read strobe, active high |
| gp_out_a | output | 1 | General-purpose output A |
| gp_out_b | output | 1 | General-purpose output B |

## Verification
The bench targets these corner cases:
- **Reset with the unit already Off.** A design that reset into the wrong mode or polarity would pull a pin Low straight after reset.
- **Each pin paired with the wrong strobe, or gating ignored.** A swapped strobe or an ignored gate would let a pin assert on the opposite command, or assert with no command at all.
- **Stale values in decode mode.** A design that leaked the polarity bit or `pmu_off` into decode mode would show the wrong level on a match.
- **Writes to the reserved neighbours of the pin registers.** An index decoder that is off by one would corrupt the control or pin settings.
- **Timing of a pin change.** A design that is combinational, or one with an extra register stage, would show the pin moving in the wrong cycle.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

    localparam int NPINS  = 2;
    localparam int ADDR_W = 7;
    localparam int REG_W  = 8;
    localparam int IDX_W  = 8;
    localparam int CTRL_W = 2 * NPINS;

    typedef enum logic [2:0] {
        ST_PWR_ON   = 3'd0,
        ST_OFF_HIGH = 3'd1,
        ST_OFF_LOW  = 3'd2,
        ST_DEC_MISS = 3'd3,
        ST_DEC_HIT  = 3'd4
    } pin_state_e;

    // Per-pin control field: bit 0 = decode mode, bit 1 = gate enable
    typedef struct packed {
        logic gate_en;
        logic dec_mode;
    } pin_mode_t;

    // Per-pin register: bit 7 polarity, bits 6..0 compare value
    typedef struct packed {
        logic              pol;
        logic [ADDR_W-1:0] cmp;
    } pin_cfg_t;

endpackage

// File: rtl/gpo_cfg_regs.sv
module gpo_cfg_regs
    import gpo_pkg::*;
#(
    parameter logic [IDX_W-1:0] CTRL_IDX     = 8'h21,
    parameter logic [IDX_W-1:0] PIN_BASE_IDX = 8'h23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   idx_wr,
    input  logic                   data_wr,
    input  logic [REG_W-1:0]       wdata,
    output pin_mode_t [NPINS-1:0]  mode_o,
    output pin_cfg_t  [NPINS-1:0]  cfg_o
);

    logic [IDX_W-1:0]      idx_q;
    pin_mode_t [NPINS-1:0] mode_q;
    pin_cfg_t  [NPINS-1:0] cfg_q;

    // Index latch; a data write in the same cycle uses the old index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_wr) begin
            idx_q <= wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (data_wr && (idx_q == CTRL_IDX)) begin
            mode_q <= wdata[CTRL_W-1:0];
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin_reg
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(PIN_BASE_IDX + i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
            end else if (data_wr && (idx_q == MY_IDX)) begin
                cfg_q[i] <= wdata;
            end
        end
    end

    assign mode_o = mode_q;
    assign cfg_o  = cfg_q;

endmodule

// File: rtl/gpo_addr_match.sv
module gpo_addr_match
    import gpo_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] cmp,
    input  logic              gate_en,
    input  logic              strobe,
    output logic              hit
);

    logic eq;

    always_comb begin
        eq  = (addr == cmp);
        hit = eq && (!gate_en || strobe);
    end

endmodule

// File: rtl/gpo_pin_fsm.sv
module gpo_pin_fsm
    import gpo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dec_mode,
    input  logic pmu_off,
    input  logic pol,
    input  logic hit,
    output logic pin
);

    pin_state_e state_q;
    pin_state_e state_d;

    // Next state: every state can reach every other in one step
    always_comb begin
        unique case (state_q)
            ST_PWR_ON, ST_OFF_HIGH, ST_OFF_LOW,
            ST_DEC_MISS, ST_DEC_HIT: begin
                if (dec_mode) begin
                    state_d = hit ? ST_DEC_HIT : ST_DEC_MISS;
                end else if (!pmu_off) begin
                    state_d = ST_PWR_ON;
                end else begin
                    state_d = pol ? ST_OFF_LOW : ST_OFF_HIGH;
                end
            end
            default: state_d = ST_PWR_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWR_ON;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode from state only
    always_comb begin
        unique case (state_q)
            ST_OFF_LOW,
            ST_DEC_HIT:  pin = 1'b0;
            ST_PWR_ON,
            ST_OFF_HIGH,
            ST_DEC_MISS: pin = 1'b1;
            default:     pin = 1'b1;
        endcase
    end

endmodule

// File: rtl/gpo_dual_ctrl.sv
module gpo_dual_ctrl
    import gpo_pkg::*;
#(
    parameter logic [IDX_W-1:0] CTRL_IDX     = 8'h21,
    parameter logic [IDX_W-1:0] PIN_BASE_IDX = 8'h23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_idx_wr,
    input  logic              cfg_data_wr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              pmu_off,
    input  logic [ADDR_W-1:0] sys_addr,
    input  logic              io_wr_act,
    input  logic              io_rd_act,
    output logic              gp_out_a,
    output logic              gp_out_b
);

    pin_mode_t [NPINS-1:0] mode_q;
    pin_cfg_t  [NPINS-1:0] cfg_q;
    logic      [NPINS-1:0] strobe_vec;
    logic      [NPINS-1:0] hit_vec;
    logic      [NPINS-1:0] pin_vec;

    // Pin A pairs with the write strobe, pin B with the read strobe
    assign strobe_vec = {io_rd_act, io_wr_act};

    gpo_cfg_regs #(
        .CTRL_IDX     (CTRL_IDX),
        .PIN_BASE_IDX (PIN_BASE_IDX)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (cfg_idx_wr),
        .data_wr (cfg_data_wr),
        .wdata   (cfg_wdata),
        .mode_o  (mode_q),
        .cfg_o   (cfg_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_chan
        gpo_addr_match u_match (
            .addr    (sys_addr),
            .cmp     (cfg_q[i].cmp),
            .gate_en (mode_q[i].gate_en),
            .strobe  (strobe_vec[i]),
            .hit     (hit_vec[i])
        );

        gpo_pin_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .dec_mode (mode_q[i].dec_mode),
            .pmu_off  (pmu_off),
            .pol      (cfg_q[i].pol),
            .hit      (hit_vec[i]),
            .pin      (pin_vec[i])
        );
    end

    assign gp_out_a = pin_vec[0];
    assign gp_out_b = pin_vec[1];

endmodule

// File: rtl/gpo_dual_ctrl_chk.sv
module gpo_dual_ctrl_chk
    import gpo_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pmu_off,
    input logic [ADDR_W-1:0]     sys_addr,
    input logic [NPINS-1:0]      strobe,
    input pin_mode_t [NPINS-1:0] mode,
    input pin_cfg_t  [NPINS-1:0] cfg,
    input logic [NPINS-1:0]      pins
);

    // R1: both pins High while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_high_r1: assert (pins == '1);
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        p_pm_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode[i].dec_mode && !pmu_off) |=> pins[i]);

        p_off_pol_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode[i].dec_mode && pmu_off) |=> (pins[i] == !$past(cfg[i].pol)));

        p_dec_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i].dec_mode && !mode[i].gate_en && (sys_addr == cfg[i].cmp))
            |=> !pins[i]);

        p_dec_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i].dec_mode && (sys_addr != cfg[i].cmp)) |=> pins[i]);

        p_gate_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i].dec_mode && mode[i].gate_en && !strobe[i]) |=> pins[i]);

        p_gate_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i].dec_mode && mode[i].gate_en && strobe[i] &&
             (sys_addr == cfg[i].cmp)) |=> !pins[i]);
    end

endmodule

bind gpo_dual_ctrl gpo_dual_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pmu_off  (pmu_off),
    .sys_addr (sys_addr),
    .strobe   (strobe_vec),
    .mode     (mode_q),
    .cfg      (cfg_q),
    .pins     (pin_vec)
);

// File: tb/gpo_dual_ctrl_bench.sv
`timescale 1ns/1ps
module gpo_dual_ctrl_bench;

    localparam logic [7:0] IDX_CTRL = 8'h21;
    localparam logic [7:0] IDX_PA   = 8'h23;
    localparam logic [7:0] IDX_PB   = 8'h24;
    localparam int NVEC = 15;

    // {ctrl[3:0], regA[7:0], regB[7:0], off, addr[6:0], wr, rd, expA, expB}
    localparam logic [31:0] VEC [NVEC] = '{
        {4'h0, 8'h00, 8'h00, 1'b0, 7'h00, 1'b0, 1'b0, 1'b1, 1'b1},
        {4'h0, 8'h80, 8'h00, 1'b1, 7'h00, 1'b0, 1'b0, 1'b0, 1'b1},
        {4'h0, 8'h00, 8'h80, 1'b1, 7'h00, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'h0, 8'h80, 8'h80, 1'b0, 7'h00, 1'b0, 1'b0, 1'b1, 1'b1},
        {4'h5, 8'h2A, 8'h55, 1'b0, 7'h2A, 1'b0, 1'b0, 1'b0, 1'b1},
        {4'h5, 8'h2A, 8'h55, 1'b0, 7'h55, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'h5, 8'hAA, 8'h55, 1'b1, 7'h2A, 1'b0, 1'b0, 1'b0, 1'b1},
        {4'h5, 8'h2A, 8'h55, 1'b0, 7'h2A, 1'b0, 1'b1, 1'b0, 1'b1},
        {4'hF, 8'h11, 8'h11, 1'b0, 7'h11, 1'b0, 1'b0, 1'b1, 1'b1},
        {4'hF, 8'h11, 8'h11, 1'b0, 7'h11, 1'b1, 1'b0, 1'b0, 1'b1},
        {4'hF, 8'h11, 8'h11, 1'b0, 7'h11, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'hF, 8'h11, 8'h11, 1'b0, 7'h11, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'hF, 8'h11, 8'h11, 1'b0, 7'h12, 1'b1, 1'b1, 1'b1, 1'b1},
        {4'h1, 8'h7F, 8'h80, 1'b1, 7'h7F, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'h4, 8'h80, 8'h00, 1'b1, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_idx_wr = 1'b0;
    logic       cfg_data_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       pmu_off = 1'b0;
    logic [6:0] sys_addr = '0;
    logic       io_wr_act = 1'b0;
    logic       io_rd_act = 1'b0;
    logic       gp_out_a;
    logic       gp_out_b;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    gpo_dual_ctrl u_gpo_dual_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_idx_wr  (cfg_idx_wr),
        .cfg_data_wr (cfg_data_wr),
        .cfg_wdata   (cfg_wdata),
        .pmu_off     (pmu_off),
        .sys_addr    (sys_addr),
        .io_wr_act   (io_wr_act),
        .io_rd_act   (io_rd_act),
        .gp_out_a    (gp_out_a),
        .gp_out_b    (gp_out_b)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic put_idx(input logic [7:0] idx);
        @(negedge clk);
        cfg_idx_wr = 1'b1;
        cfg_wdata  = idx;
        @(negedge clk);
        cfg_idx_wr = 1'b0;
    endtask

    task automatic put_data(input logic [7:0] val);
        @(negedge clk);
        cfg_data_wr = 1'b1;
        cfg_wdata   = val;
        @(negedge clk);
        cfg_data_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] val);
        put_idx(idx);
        put_data(val);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        string tag;
        logic [31:0] v;

        // R1: reset with the unit Off
        pmu_off = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "pin A in reset", gp_out_a, 1'b1);
        check("R1", "pin B in reset", gp_out_b, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "pin A after reset", gp_out_a, 1'b1);
        check("R1", "pin B after reset", gp_out_b, 1'b1);
        // Power mode by default: polarity write alone pulls pin A Low
        wr_reg(IDX_PA, 8'h80);
        @(negedge clk);
        check("R1", "default mode is power", gp_out_a, 1'b0);
        wr_reg(IDX_PA, 8'h00);

        // Vector table walk
        for (int k = 0; k < NVEC; k++) begin
            v = VEC[k];
            wr_reg(IDX_CTRL, {4'h0, v[31:28]});
            wr_reg(IDX_PA, v[27:20]);
            wr_reg(IDX_PB, v[19:12]);
            @(negedge clk);
            pmu_off   = v[11];
            sys_addr  = v[10:4];
            io_wr_act = v[3];
            io_rd_act = v[2];
            @(negedge clk);
            if (v[31:28] == 4'h0) tag = v[11] ? "R4" : "R3";
            else if (v[29] || v[31]) tag = "R6";
            else tag = "R5";
            check(tag, $sformatf("vec %0d pin A", k), gp_out_a, v[1]);
            check(tag, $sformatf("vec %0d pin B", k), gp_out_b, v[0]);
        end
        io_wr_act = 1'b0;
        io_rd_act = 1'b0;

        // R8: upper control bits have no effect
        pmu_off = 1'b0;
        wr_reg(IDX_CTRL, 8'hF0);
        wr_reg(IDX_PA, 8'h80);
        wr_reg(IDX_PB, 8'h00);
        @(negedge clk);
        sys_addr = 7'h00;
        pmu_off  = 1'b1;
        @(negedge clk);
        check("R8", "ctrl 0xF0 keeps A in power mode", gp_out_a, 1'b0);
        check("R8", "ctrl 0xF0 keeps B in power mode", gp_out_b, 1'b1);

        // R2: index persists over several data writes
        put_idx(IDX_PB);
        put_data(8'h00);
        put_data(8'h80);
        @(negedge clk);
        check("R2", "second data write reaches B", gp_out_b, 1'b0);
        put_data(8'h00);
        @(negedge clk);
        check("R2", "third data write reaches B", gp_out_b, 1'b1);
        check("R2", "A untouched by B writes", gp_out_a, 1'b0);

        // R7: latency of exactly one clock
        wr_reg(IDX_CTRL, 8'h01);
        wr_reg(IDX_PA, 8'h33);
        @(negedge clk);
        sys_addr = 7'h00;
        @(negedge clk);
        check("R7", "A high before match", gp_out_a, 1'b1);
        sys_addr = 7'h33;
        #1;
        check("R7", "A not yet low", gp_out_a, 1'b1);
        @(negedge clk);
        check("R7", "A low one clock later", gp_out_a, 1'b0);
        sys_addr = 7'h34;
        #1;
        check("R7", "A not yet released", gp_out_a, 1'b0);
        @(negedge clk);
        check("R7", "A high one clock later", gp_out_a, 1'b1);
        sys_addr = 7'h33;
        @(negedge clk);

        // R9: reserved and unknown indexes have no effect
        wr_reg(8'h22, 8'h00);
        wr_reg(8'h25, 8'hFF);
        wr_reg(8'h26, 8'hFF);
        wr_reg(8'h27, 8'hFF);
        wr_reg(8'h28, 8'hFF);
        wr_reg(8'h20, 8'h00);
        @(negedge clk);
        check("R9", "A still decoding", gp_out_a, 1'b0);
        check("R9", "B polarity unchanged", gp_out_b, 1'b1);
        sys_addr = 7'h32;
        @(negedge clk);
        check("R9", "A compare value unchanged", gp_out_a, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule